// File: doc/BRIEF.md
# Staged Multi-Channel Configuration Register File

This block holds the configuration state of a ten-lane converter: eight data lanes, a frame-clock lane and a data-clock lane. A simple parallel port carries the accesses: an address, a write strobe with write data, and a read path that returns data in the same cycle. Two lane-select registers form a ten-bit mask. A write to the per-lane pattern register reaches only the lanes whose mask bit is set. A read of that register returns the value held by the lowest-numbered selected lane.

The per-lane pattern registers, the global power-mode field and the global stabilizer-enable bit each have two copies. Writes land in the staging (master) copy. The live (slave) copy, which drives the output ports, changes only when software issues a commit command, and one clock edge then copies every staging copy to its live copy. The block also holds a port-setup register, a read-only identity value and a speed-grade field. In the port-setup register, the bit-order flag and the soft-reset flag each sit in two mirrored positions. A soft reset returns every register to its default one cycle after it is requested.

Top module: `cfg_shadow_regs`

## Requirements
- R1: After reset the registers read as follows: 0x00 reads 0x18, 0x01 reads CHIP_ID, 0x02 reads 0x00, 0x04 and 0x05 read 0x0F, 0x08 reads 0x00 and 0x09 reads 0x01. All live pattern outputs are 0 and dcs_en is 1.
- R2: Port setup (0x00) reads {0, L, S, 1, 1, S, L, 0} from bit 7 down to bit 0. A write sets L if data bit 6 or bit 1 is 1, and sets S if bit 5 or bit 2 is 1. L drives lsb_first.
- R3: When a write sets S, the next cycle reads 0x00 with S set. On the following edge every staging and live register returns to its R1 default, and S clears. Accesses made while S is set are dropped.
- R4: Address 0x01 always reads CHIP_ID, and writes to it change nothing.
- R5: Address 0x02 stores data bits 5:4 as the grade code (00 = 40 MSPS, 01 = 25 MSPS, 10 = 50 MSPS) and drives the grade output. Its other bits read 0.
- R6: Address 0x05 bits 3:0 select lanes 0–3, bit 4 selects lane 8 (frame clock) and bit 5 selects lane 9 (data clock). Address 0x04 bits 3:0 select lanes 4–7. Unused bits read 0.
- R7: A write to 0x0D updates the staging copy of exactly the selected lanes.
- R8: A read of 0x0D returns the staging value of the lowest-numbered selected lane, or 0x00 when no lane is selected.
- R9: Live copies do not change until a write to 0xFF with bit 0 set. At that edge every staging copy is copied to its live copy. Lane n drives ch_pattern[8n+7:8n]. Address 0xFF always reads 0.
- R10: Address 0x08 bits 2:0 hold the power mode (000 run, 001 full off, 010 standby, 011 reset, 100 CW). A read returns the staging value, and the pwr_mode output carries the live value.
- R11: Address 0x09 bit 0 holds the stabilizer enable. A read returns the staging value, and the dcs_en output carries the live value.
- R12: An unmapped address reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, same cycle |
| lsb_first | output | 1 | Bit-order flag |
| grade | output | 2 | Speed-grade code |
| pwr_mode | output | 3 | Live power mode |
| dcs_en | output | 1 | Live stabilizer enable |
| ch_pattern | output | 80 | Live per-lane pattern values, lane n at bits 8n+7:8n |

## Verification
The lane-steered writes are tried with four kinds of mask: a single lane, an adjacent pair, a mask that spans both select registers and includes the clock lanes, and an empty mask. These tell apart steering by mask bit from steering by register, and show whether lanes 8 and 9 are mapped correctly. Read-back is tried with masks whose lowest bit differs, which exposes the wrong priority direction. Commits are issued both with bit 0 clear and with bit 0 set, which tells a true commit from any write to 0xFF. Soft reset is requested through each of the two mirrored flag positions.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;
   localparam int NUM_CH  = 10;
   localparam int REG_W   = 8;
   localparam int IDX_W   = $clog2(NUM_CH);

   localparam logic [7:0] A_PORT   = 8'h00;
   localparam logic [7:0] A_ID     = 8'h01;
   localparam logic [7:0] A_GRADE  = 8'h02;
   localparam logic [7:0] A_SEL_HI = 8'h04;
   localparam logic [7:0] A_SEL_LO = 8'h05;
   localparam logic [7:0] A_PWR    = 8'h08;
   localparam logic [7:0] A_CLK    = 8'h09;
   localparam logic [7:0] A_PAT    = 8'h0D;
   localparam logic [7:0] A_COMMIT = 8'hFF;

   localparam logic [3:0] SEL_HI_RST = 4'hF;
   localparam logic [5:0] SEL_LO_RST = 6'h0F;
endpackage

// File: rtl/cfg_stage_reg.sv
module cfg_stage_reg #(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         commit,
   output logic [W-1:0] master,
   output logic [W-1:0] slave
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master <= RST;
         slave  <= RST;
      end else if (clr) begin
         master <= RST;
         slave  <= RST;
      end else begin
         if (wr)     master <= wdata;
         if (commit) slave  <= master;
      end
   end
endmodule

// File: rtl/cfg_chan_sel.sv
module cfg_chan_sel
   import cfg_regs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic [5:0]       wsel,
   output logic [3:0]       sel_hi,
   output logic [5:0]       sel_lo,
   output logic [NUM_CH-1:0] ch_sel,
   output logic             any_sel,
   output logic [IDX_W-1:0] low_idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_hi <= SEL_HI_RST;
         sel_lo <= SEL_LO_RST;
      end else if (clr) begin
         sel_hi <= SEL_HI_RST;
         sel_lo <= SEL_LO_RST;
      end else begin
         if (wr_hi) sel_hi <= wsel[3:0];
         if (wr_lo) sel_lo <= wsel;
      end
   end

   // lanes 0-3 low reg, 4-7 high reg, 8/9 clock lanes from low reg bits 4/5
   assign ch_sel  = {sel_lo[5:4], sel_hi, sel_lo[3:0]};
   assign any_sel = |ch_sel;

   always_comb begin
      low_idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (ch_sel[i]) low_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/cfg_chan_bank.sv
module cfg_chan_bank
   import cfg_regs_pkg::*;
#(
   parameter logic [REG_W-1:0] PAT_RST = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr,
   input  logic [REG_W-1:0]        wdata,
   input  logic [NUM_CH-1:0]       ch_sel,
   input  logic                    commit,
   input  logic                    any_sel,
   input  logic [IDX_W-1:0]        low_idx,
   output logic [REG_W-1:0]        rd_val,
   output logic [NUM_CH*REG_W-1:0] live
);
   logic [REG_W-1:0] stage [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      cfg_stage_reg #(.W(REG_W), .RST(PAT_RST)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .wr     (wr && ch_sel[g]),
         .wdata  (wdata),
         .commit (commit),
         .master (stage[g]),
         .slave  (live[g*REG_W +: REG_W])
      );
   end

   assign rd_val = any_sel ? stage[low_idx] : '0;
endmodule

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs
   import cfg_regs_pkg::*;
#(
   parameter logic [7:0] CHIP_ID = 8'h2F,
   parameter int         AW      = 8,
   parameter logic       DCS_RST = 1'b1,
   parameter logic [7:0] PAT_RST = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           addr,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   output logic                    lsb_first,
   output logic [1:0]              grade,
   output logic [2:0]              pwr_mode,
   output logic                    dcs_en,
   output logic [NUM_CH*REG_W-1:0] ch_pattern
);
   if (AW < 8) begin : g_bad_aw
      $error("cfg_shadow_regs: AW must be at least 8");
   end
   if (REG_W != 8) begin : g_bad_w
      $error("cfg_shadow_regs: register width must be 8");
   end

   logic soft_q, lsb_q;
   logic [1:0] grade_q;
   logic wr_port, wr_grade, wr_hi, wr_lo, wr_pwr, wr_clk, wr_pat, commit;

   assign wr_port  = wr_en && (addr == AW'(A_PORT));
   assign wr_grade = wr_en && (addr == AW'(A_GRADE));
   assign wr_hi    = wr_en && (addr == AW'(A_SEL_HI));
   assign wr_lo    = wr_en && (addr == AW'(A_SEL_LO));
   assign wr_pwr   = wr_en && (addr == AW'(A_PWR));
   assign wr_clk   = wr_en && (addr == AW'(A_CLK));
   assign wr_pat   = wr_en && (addr == AW'(A_PAT));
   assign commit   = wr_en && (addr == AW'(A_COMMIT)) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q  <= 1'b0;
         lsb_q   <= 1'b0;
         grade_q <= 2'b00;
      end else if (soft_q) begin
         soft_q  <= 1'b0;
         lsb_q   <= 1'b0;
         grade_q <= 2'b00;
      end else begin
         if (wr_port) begin
            soft_q <= wdata[5] | wdata[2];
            lsb_q  <= wdata[6] | wdata[1];
         end
         if (wr_grade) grade_q <= wdata[5:4];
      end
   end

   logic [3:0]        sel_hi;
   logic [5:0]        sel_lo;
   logic [NUM_CH-1:0] ch_sel;
   logic              any_sel;
   logic [IDX_W-1:0]  low_idx;

   cfg_chan_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_q),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wsel    (wdata[5:0]),
      .sel_hi  (sel_hi),
      .sel_lo  (sel_lo),
      .ch_sel  (ch_sel),
      .any_sel (any_sel),
      .low_idx (low_idx)
   );

   logic [7:0] pat_rd;

   cfg_chan_bank #(.PAT_RST(PAT_RST)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_q),
      .wr      (wr_pat),
      .wdata   (wdata),
      .ch_sel  (ch_sel),
      .commit  (commit),
      .any_sel (any_sel),
      .low_idx (low_idx),
      .rd_val  (pat_rd),
      .live    (ch_pattern)
   );

   logic [2:0] pwr_stage;
   logic       dcs_stage;

   cfg_stage_reg #(.W(3), .RST(3'b000)) u_pwr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_q),
      .wr     (wr_pwr),
      .wdata  (wdata[2:0]),
      .commit (commit),
      .master (pwr_stage),
      .slave  (pwr_mode)
   );

   cfg_stage_reg #(.W(1), .RST(DCS_RST)) u_dcs (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_q),
      .wr     (wr_clk),
      .wdata  (wdata[0]),
      .commit (commit),
      .master (dcs_stage),
      .slave  (dcs_en)
   );

   always_comb begin
      rdata = 8'h00;
      if      (addr == AW'(A_PORT))   rdata = {1'b0, lsb_q, soft_q, 2'b11, soft_q, lsb_q, 1'b0};
      else if (addr == AW'(A_ID))     rdata = CHIP_ID;
      else if (addr == AW'(A_GRADE))  rdata = {2'b00, grade_q, 4'h0};
      else if (addr == AW'(A_SEL_HI)) rdata = {4'h0, sel_hi};
      else if (addr == AW'(A_SEL_LO)) rdata = {2'b00, sel_lo};
      else if (addr == AW'(A_PWR))    rdata = {5'b0, pwr_stage};
      else if (addr == AW'(A_CLK))    rdata = {7'b0, dcs_stage};
      else if (addr == AW'(A_PAT))    rdata = pat_rd;
   end

   assign lsb_first = lsb_q;
   assign grade     = grade_q;
endmodule

// File: rtl/cfg_shadow_regs_chk.sv
module cfg_shadow_regs_chk
   import cfg_regs_pkg::*;
#(
   parameter logic [7:0] CHIP_ID = 8'h2F,
   parameter int         AW      = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [AW-1:0]           addr,
   input logic                    xfer_bit,
   input logic [7:0]              rdata,
   input logic                    soft_q,
   input logic                    lsb_first,
   input logic [2:0]              pwr_mode,
   input logic                    dcs_en,
   input logic [NUM_CH*REG_W-1:0] ch_pattern
);
   logic xfer;
   assign xfer = wr_en && (addr == AW'(A_COMMIT)) && xfer_bit;

   // R9: live lane values move only on commit or soft reset
   a_r9_live_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_pattern) |-> ($past(xfer) || $past(soft_q)));

   // R10: live power mode moves only on commit or soft reset
   a_r10_pwr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_mode) |-> ($past(xfer) || $past(soft_q)));

   // R11: live stabilizer bit moves only on commit or soft reset
   a_r11_dcs_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dcs_en) |-> ($past(xfer) || $past(soft_q)));

   // R9: commit address reads zero
   a_r9_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(A_COMMIT)) |-> (rdata == 8'h00));

   // R4: identity constant
   a_r4_id_const: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(A_ID)) |-> (rdata == CHIP_ID));

   // R2: mirrored nibbles in port setup
   a_r2_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(A_PORT)) |-> (rdata[6] == rdata[1] && rdata[5] == rdata[2]
                                 && rdata[4:3] == 2'b11 && !rdata[7] && !rdata[0]));

   // R3: soft reset clears itself and restores defaults
   a_r3_soft_restore: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q |=> (!soft_q && !lsb_first && pwr_mode == 3'b000 && dcs_en
                  && ch_pattern == '0));
endmodule

bind cfg_shadow_regs cfg_shadow_regs_chk #(.CHIP_ID(CHIP_ID), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .xfer_bit   (wdata[0]),
   .rdata      (rdata),
   .soft_q     (soft_q),
   .lsb_first  (lsb_first),
   .pwr_mode   (pwr_mode),
   .dcs_en     (dcs_en),
   .ch_pattern (ch_pattern)
);

// File: tb/cfg_shadow_regs_tb.sv
`timescale 1ns/1ps
module cfg_shadow_regs_tb;
   localparam int NCH = 10;
   localparam logic [7:0] ID = 8'h2F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic lsb_first, dcs_en;
   logic [1:0] grade;
   logic [2:0] pwr_mode;
   logic [NCH*8-1:0] ch_pattern;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cfg_shadow_regs #(.CHIP_ID(ID)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lsb_first(lsb_first), .grade(grade), .pwr_mode(pwr_mode),
      .dcs_en(dcs_en), .ch_pattern(ch_pattern)
   );

   // behavioural reference
   bit m_lsb, m_soft;
   int m_grade, m_hi, m_lo, m_pwr_s, m_pwr_l, m_dcs_s, m_dcs_l;
   int m_pat_s [NCH];
   int m_pat_l [NCH];

   function automatic bit lane_on(int i);
      if (i < 4) return m_lo[i];
      if (i < 8) return m_hi[i-4];
      return m_lo[i-4];
   endfunction

   function automatic void m_defaults();
      m_lsb = 0; m_soft = 0; m_grade = 0; m_hi = 'hF; m_lo = 'hF;
      m_pwr_s = 0; m_pwr_l = 0; m_dcs_s = 1; m_dcs_l = 1;
      for (int i = 0; i < NCH; i++) begin m_pat_s[i] = 0; m_pat_l[i] = 0; end
   endfunction

   function automatic int m_read(int a);
      case (a)
         'h00: return (m_lsb << 6) | (m_soft << 5) | 'h18 | (m_soft << 2) | (m_lsb << 1);
         'h01: return ID;
         'h02: return m_grade << 4;
         'h04: return m_hi;
         'h05: return m_lo;
         'h08: return m_pwr_s;
         'h09: return m_dcs_s;
         'h0D: begin
            for (int i = 0; i < NCH; i++) if (lane_on(i)) return m_pat_s[i];
            return 0;
         end
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int a);
      case (a)
         'h00: return "R2"; 'h01: return "R4"; 'h02: return "R5";
         'h04, 'h05: return "R6"; 'h08: return "R10"; 'h09: return "R11";
         'h0D: return "R8"; 'hFF: return "R9";
         default: return "R12";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n || m_soft) m_defaults();
      else if (wr_en) begin
         case (addr)
            'h00: begin m_soft = wdata[5] | wdata[2]; m_lsb = wdata[6] | wdata[1]; end
            'h02: m_grade = wdata[5:4];
            'h04: m_hi = wdata[3:0];
            'h05: m_lo = wdata[5:0];
            'h08: m_pwr_s = wdata[2:0];
            'h09: m_dcs_s = wdata[0];
            'h0D: for (int i = 0; i < NCH; i++) if (lane_on(i)) m_pat_s[i] = wdata;
            'hFF: if (wdata[0]) begin
               m_pwr_l = m_pwr_s; m_dcs_l = m_dcs_s;
               for (int i = 0; i < NCH; i++) m_pat_l[i] = m_pat_s[i];
            end
            default: ;
         endcase
      end
   end

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #3;
         check(tag_of(addr), rdata, m_read(addr), "rdata");
         check("R2", lsb_first, m_lsb, "lsb_first");
         check("R5", grade, m_grade, "grade");
         check("R10", pwr_mode, m_pwr_l, "pwr_mode");
         check("R11", dcs_en, m_dcs_l, "dcs_en");
         for (int i = 0; i < NCH; i++)
            check("R9", ch_pattern[i*8 +: 8], m_pat_l[i], "lane live");
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 8'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, int exp, string req);
      @(negedge clk);
      addr = 8'(a);
      #2;
      check(req, rdata, exp, "directed read");
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_defaults();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 defaults
      rd('h00, 'h18, "R1"); rd('h01, ID, "R1"); rd('h02, 0, "R1");
      rd('h04, 'h0F, "R1"); rd('h05, 'h0F, "R1"); rd('h08, 0, "R1"); rd('h09, 1, "R1");
      check("R1", dcs_en, 1, "dcs_en reset"); check("R1", ch_pattern == '0, 1, "lanes reset");
      // R7/R8 single lane A
      wr('h04, 'h00); wr('h05, 'h01); wr('h0D, 'hA5);
      rd('h0D, 'hA5, "R7");
      check("R9", ch_pattern == '0, 1, "no commit yet");
      wr('h05, 'h02); rd('h0D, 'h00, "R7");
      wr('h05, 'h06); wr('h0D, 'h3C);
      wr('h05, 'h07); rd('h0D, 'hA5, "R8");
      wr('h05, 'h00); rd('h0D, 'h00, "R8");
      // R6 span of both registers plus clock lanes
      wr('h04, 'hF1); rd('h04, 'h01, "R6");
      wr('h05, 'hF0); rd('h05, 'h30, "R6");
      wr('h0D, 'h77);
      wr('h04, 'h00); wr('h05, 'h20); rd('h0D, 'h77, "R7");
      wr('h05, 'h08); rd('h0D, 'h00, "R7");
      // R10/R11 staging
      wr('h08, 'h02); wr('h09, 'h00);
      rd('h08, 'h02, "R10"); rd('h09, 'h00, "R11");
      check("R10", pwr_mode, 0, "live before commit");
      check("R11", dcs_en, 1, "live before commit");
      wr('hFF, 'h00);
      check("R9", ch_pattern == '0, 1, "commit with bit0 clear");
      wr('hFF, 'h01);
      rd('hFF, 'h00, "R9");
      check("R9", ch_pattern[0 +: 8], 'hA5, "lane0 live");
      check("R9", ch_pattern[16 +: 8], 'h3C, "lane2 live");
      check("R9", ch_pattern[32 +: 8], 'h77, "lane4 live");
      check("R9", ch_pattern[72 +: 8], 'h77, "lane9 live");
      check("R9", ch_pattern[24 +: 8], 'h00, "lane3 live");
      check("R10", pwr_mode, 2, "live after commit");
      check("R11", dcs_en, 0, "live after commit");
      wr('h08, 'h04); wr('hFF, 'hFE);
      check("R10", pwr_mode, 2, "even data no commit");
      wr('hFF, 'h01);
      check("R10", pwr_mode, 4, "CW live");
      // R2 mirrored flag
      wr('h00, 'h40); rd('h00, 'h5A, "R2"); check("R2", lsb_first, 1, "upper copy");
      wr('h00, 'h00); rd('h00, 'h18, "R2");
      wr('h00, 'h02); rd('h00, 'h5A, "R2"); check("R2", lsb_first, 1, "lower copy");
      // R4, R5, R12
      wr('h01, 'h55); rd('h01, ID, "R4");
      wr('h02, 'hFF); rd('h02, 'h30, "R5"); check("R5", grade, 3, "grade out");
      wr('h02, 'h20); rd('h02, 'h20, "R5");
      wr('h03, 'hFF); rd('h03, 'h00, "R12");
      wr('h80, 'h12); rd('h80, 'h00, "R12"); rd('h0E, 'h00, "R12");
      // R3 soft reset via lower copy
      wr('h05, 'h01); wr('h0D, 'h99);
      wr('h00, 'h04);
      addr = 8'h00; #2;
      check("R3", rdata, 'h3C | (m_lsb ? 'h42 : 0), "pending soft");
      rd('h00, 'h18, "R3"); rd('h05, 'h0F, "R3"); rd('h0D, 'h00, "R3");
      rd('h09, 'h01, "R3"); rd('h02, 'h00, "R3");
      check("R3", pwr_mode, 0, "pwr after soft");
      check("R3", ch_pattern == '0, 1, "lanes after soft");
      // R3 via upper copy, write during pending dropped
      wr('h08, 'h01);
      @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 8'h20;
      @(negedge clk); addr = 8'h08; wdata = 8'h03;
      @(negedge clk); wr_en = 1'b0;
      rd('h08, 'h00, "R3");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule